// File: doc/BRIEF.md
# Tile row chunk extractor

The block holds a small two-dimensional tile of data, 16 rows of 64 bytes by default, and reads out one 512-bit chunk of a chosen row as a vector result. A single 32-bit selector word names the row and the chunk. Its low half is the row index. Its high half is a chunk number, and the chunk's byte offset inside the row is that number times the vector width in bytes.

Each request also carries a valid row width in bytes. Positions at or past this width are forced to zero. In the raw move mode the zeroing works byte by byte. In the converting mode it works on whole 32-bit lanes, so a lane that is only partly inside the width is cleared completely. The result is registered and marked by a one-cycle valid pulse. A per-lane valid mask goes with it, so that a downstream lane converter knows which raw dwords carry data. A row index at or past the configured row count gives an all-zero result. A plain write port loads rows for test.

Top module: `tile_row_extract`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `res_valid` is 0, `res_data` is all zeros and `res_lane_mask` is all zeros.
- R2: A cycle with `req` high produces `res_valid` high in the next cycle only. In a cycle after one without `req`, `res_valid` is 0 and `res_data` and `res_lane_mask` keep their previous values.
- R3: The row index is `sel[15:0]` and the chunk number is `sel[31:16]`. With chunk 0, a row width of 64 and a valid row, result byte i (bits 8i+7..8i) equals byte i of the selected row in both modes.
- R4: With `mode` = 0 (raw move), result byte i is zero when offset+i is at least the row width. Otherwise it is byte offset+i of the row, where offset = chunk*64.
- R5: With `mode` = 1 (dword converting), result lane i (bits 32i+31..32i) is zero when i+offset/4 is at least floor(width/4). Otherwise it carries the row's dword offset/4+i unchanged.
- R6: A row index that is at or above `cfg_rows`, or at or above 16, gives all-zero `res_data` and `res_lane_mask`.
- R7: A `cfg_colsb` value above 64 behaves exactly as 64.
- R8: `res_lane_mask` bit i is 1 exactly when lane i passes the dword test of R5 in mode 1. In mode 0 it is 1 exactly when byte 4i of the result passes the byte test of R4. In both cases it is also 0 for a row rejected by R6.
- R9: Any nonzero chunk number gives an all-zero result, because its offset is at least the row length.
- R10: With `wr_en` high, `wr_data` replaces row `wr_row` at the clock edge. A request in any later cycle reads the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Test write strobe for one tile row |
| wr_row | input | 4 | Row written by the test port |
| wr_data | input | 512 | Row contents for the test write |
| req | input | 1 | Extraction request strobe |
| sel | input | 32 | Selector: row index in bits 15..0, chunk number in bits 31..16 |
| mode | input | 1 | 0 = raw byte move, 1 = dword converting lanes |
| cfg_colsb | input | 7 | Valid row width in bytes, sampled with the request |
| cfg_rows | input | 5 | Number of configured rows, sampled with the request |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 512 | Extracted chunk with masked positions zeroed |
| res_lane_mask | output | 16 | Per-lane valid mask for the lane converter |

## Verification
Row widths that are not multiples of four, such as 6 or 61, are run in both modes. They separate the byte-granular cut of the raw move from the whole-lane cut of the converting mode. Widths of 0, 64 and above 64 probe the clamp and the two empty/full extremes. Nonzero and maximal chunk numbers, and row indices on either side of the configured row count and of the tile depth, test the selector decode. Seeded random selectors, widths and modes over a randomly filled tile catch offset and indexing slips that the directed cases miss.

// File: rtl/tre_pkg.sv
package tre_pkg;
   typedef enum logic {
      MODE_RAW   = 1'b0,
      MODE_DWORD = 1'b1
   } tre_mode_e;
endpackage

// File: rtl/tre_storage.sv
module tre_storage #(
   parameter int  ROWS           = 16,
   parameter int  ROW_BYTES      = 64,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int RI_W           = $clog2(ROWS),
   localparam int RW             = ROW_BYTES * 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [RI_W-1:0] wr_row,
   input  logic [RW-1:0]   wr_data,
   input  logic [RI_W-1:0] rd_row,
   output logic [RW-1:0]   rd_data
);
   logic [RW-1:0] mem [ROWS];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int r = 0; r < ROWS; r++) mem[r] <= '0;
            end else if (wr_en) begin
               mem[wr_row] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_row] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_row];
endmodule

// File: rtl/tre_mask_gen.sv
module tre_mask_gen
   import tre_pkg::*;
#(
   parameter int  VEC_BYTES = 64,
   parameter int  ROW_BYTES = 64,
   parameter int  CB_W      = 7,
   localparam int LANES     = VEC_BYTES / 4
) (
   input  logic [15:0]          chunk,
   input  tre_mode_e            mode,
   input  logic [CB_W-1:0]      colsb,
   input  logic                 row_ok,
   output logic [VEC_BYTES-1:0] byte_keep,
   output logic [LANES-1:0]     lane_mask
);
   logic [31:0] lim_b, lim_d, off_b, off_d;

   assign lim_b = (32'(colsb) > 32'(ROW_BYTES)) ? 32'(ROW_BYTES) : 32'(colsb);
   assign lim_d = lim_b >> 2;
   assign off_b = 32'(chunk) * 32'(VEC_BYTES);
   assign off_d = off_b >> 2;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic       dw_ok;
         logic [3:0] by_ok;
         assign dw_ok = row_ok && ((off_d + 32'(g)) < lim_d);
         for (genvar b = 0; b < 4; b++) begin : g_byte
            assign by_ok[b] = row_ok && ((off_b + 32'(4*g + b)) < lim_b);
         end
         assign byte_keep[4*g +: 4] = (mode == MODE_DWORD) ? {4{dw_ok}} : by_ok;
         assign lane_mask[g]        = (mode == MODE_DWORD) ? dw_ok : by_ok[0];
      end
   endgenerate
endmodule

// File: rtl/tre_chunk_sel.sv
module tre_chunk_sel #(
   parameter int VEC_BYTES = 64
) (
   input  logic [VEC_BYTES*8-1:0] row_data,
   input  logic [VEC_BYTES-1:0]   byte_keep,
   output logic [VEC_BYTES*8-1:0] vec
);
   generate
      for (genvar i = 0; i < VEC_BYTES; i++) begin : g_b
         assign vec[8*i +: 8] = byte_keep[i] ? row_data[8*i +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/tile_row_extract.sv
module tile_row_extract
   import tre_pkg::*;
#(
   parameter int  ROWS           = 16,
   parameter int  ROW_BYTES      = 64,
   parameter int  VEC_BYTES      = 64,
   parameter int  CB_W           = 7,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int RI_W           = $clog2(ROWS),
   localparam int RC_W           = $clog2(ROWS + 1),
   localparam int LANES          = VEC_BYTES / 4,
   localparam int VW             = VEC_BYTES * 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [RI_W-1:0]      wr_row,
   input  logic [ROW_BYTES*8-1:0] wr_data,
   input  logic                 req,
   input  logic [31:0]          sel,
   input  logic                 mode,
   input  logic [CB_W-1:0]      cfg_colsb,
   input  logic [RC_W-1:0]      cfg_rows,
   output logic                 res_valid,
   output logic [VW-1:0]        res_data,
   output logic [LANES-1:0]     res_lane_mask
);
   generate
      if (VEC_BYTES % 4 != 0) begin : g_bad_vec
         $error("VEC_BYTES must be a multiple of 4");
      end
      if (ROW_BYTES != VEC_BYTES) begin : g_bad_row
         $error("ROW_BYTES must equal VEC_BYTES");
      end
      if (ROWS < 2 || ROWS > 65536) begin : g_bad_rows
         $error("ROWS out of range");
      end
      if (ROW_BYTES >= (1 << CB_W)) begin : g_bad_cb
         $error("CB_W too narrow for ROW_BYTES");
      end
   endgenerate

   logic [15:0]          row_idx, chunk;
   logic                 row_ok;
   logic [VW-1:0]        row_data, vec;
   logic [VEC_BYTES-1:0] byte_keep;
   logic [LANES-1:0]     lane_mask;
   tre_mode_e            mode_e;

   assign row_idx = sel[15:0];
   assign chunk   = sel[31:16];
   assign mode_e  = tre_mode_e'(mode);
   assign row_ok  = (32'(row_idx) < 32'(ROWS)) && (32'(row_idx) < 32'(cfg_rows));

   tre_storage #(
      .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_data(wr_data), .rd_row(row_idx[RI_W-1:0]), .rd_data(row_data)
   );

   tre_mask_gen #(
      .VEC_BYTES(VEC_BYTES), .ROW_BYTES(ROW_BYTES), .CB_W(CB_W)
   ) u_mask (
      .chunk(chunk), .mode(mode_e), .colsb(cfg_colsb), .row_ok(row_ok),
      .byte_keep(byte_keep), .lane_mask(lane_mask)
   );

   tre_chunk_sel #(.VEC_BYTES(VEC_BYTES)) u_sel (
      .row_data(row_data), .byte_keep(byte_keep), .vec(vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_data      <= '0;
         res_lane_mask <= '0;
      end else begin
         res_valid <= req;
         if (req) begin
            res_data      <= vec;
            res_lane_mask <= lane_mask;
         end
      end
   end
endmodule

// File: rtl/tre_checker.sv
module tre_checker #(
   parameter int VEC_BYTES = 64,
   parameter int RC_W      = 5,
   parameter int CB_W      = 7,
   localparam int LANES    = VEC_BYTES / 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req,
   input logic [31:0]            sel,
   input logic                   mode,
   input logic [CB_W-1:0]        cfg_colsb,
   input logic [RC_W-1:0]        cfg_rows,
   input logic                   res_valid,
   input logic [VEC_BYTES*8-1:0] res_data,
   input logic [LANES-1:0]       res_lane_mask
);
   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> res_valid); // R2
   AST_VALID_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(req)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req) |-> ($stable(res_data) && $stable(res_lane_mask))); // R2
   AST_BAD_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (32'($past(sel[15:0])) >= 32'($past(cfg_rows))))
      |-> (res_data == '0 && res_lane_mask == '0)); // R6
   AST_CHUNK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(sel[31:16]) != 16'd0) |-> (res_data == '0)); // R9
   AST_MASK_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((res_lane_mask & (res_lane_mask + 1'b1)) == '0)); // R8
   AST_WIDTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(cfg_colsb) == '0) |-> (res_data == '0)); // R4

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && $past(mode) && !res_lane_mask[g])
            |-> (res_data[32*g +: 32] == 32'h0)); // R5
      end
   endgenerate
endmodule

bind tile_row_extract tre_checker #(
   .VEC_BYTES(VEC_BYTES), .RC_W(RC_W), .CB_W(CB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .sel(sel), .mode(mode),
   .cfg_colsb(cfg_colsb), .cfg_rows(cfg_rows), .res_valid(res_valid),
   .res_data(res_data), .res_lane_mask(res_lane_mask)
);

// File: tb/tile_row_extract_tb_top.sv
`timescale 1ns/1ps
module tile_row_extract_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_row = '0;
   logic [511:0] wr_data = '0;
   logic         req = 1'b0;
   logic [31:0]  sel = '0;
   logic         mode = 1'b0;
   logic [6:0]   cfg_colsb = 7'd64;
   logic [4:0]   cfg_rows = 5'd16;
   logic         res_valid;
   logic [511:0] res_data;
   logic [15:0]  res_lane_mask;

   int checks = 0;
   int failures = 0;
   logic [511:0] mem [16];

   always #10 clk = ~clk;

   tile_row_extract dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_data(wr_data), .req(req), .sel(sel), .mode(mode),
      .cfg_colsb(cfg_colsb), .cfg_rows(cfg_rows), .res_valid(res_valid),
      .res_data(res_data), .res_lane_mask(res_lane_mask)
   );

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
      return v;
   endfunction

   function automatic void model(input logic [31:0] s, input logic m,
                                 input logic [6:0] cb, input logic [4:0] rc,
                                 output logic [511:0] d, output logic [15:0] mk);
      int row, off, ce;
      bit rowok, keep;
      row   = int'(s[15:0]);
      off   = int'(s[31:16]) * 64;
      ce    = (int'(cb) > 64) ? 64 : int'(cb);
      rowok = (row < int'(rc)) && (row < 16);
      d = '0;
      mk = '0;
      for (int i = 0; i < 64; i++) begin
         keep = rowok && (m ? ((i/4 + off/4) < ce/4) : ((off + i) < ce));
         if (keep) d[8*i +: 8] = mem[row][8*(off + i) +: 8];
      end
      for (int l = 0; l < 16; l++)
         mk[l] = rowok && (m ? ((l + off/4) < ce/4) : ((off + 4*l) < ce));
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_row(input int r, input logic [511:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_row = 4'(r); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      mem[r] = v;
   endtask

   task automatic do_req(input logic [31:0] s, input logic m, input logic [6:0] cb,
                         input logic [4:0] rc, input string tag);
      logic [511:0] ed;
      logic [15:0]  em;
      model(s, m, cb, rc, ed, em);
      sel = s; mode = m; cfg_colsb = cb; cfg_rows = rc; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(res_valid === 1'b1, {tag, " R2 valid"}, 512'(res_valid), 512'(1));
      chk(res_data === ed, {tag, " data"}, res_data, ed);
      chk(res_lane_mask === em, {tag, " R8 mask"}, 512'(res_lane_mask), 512'(em));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [511:0] held;
      void'($urandom(32'h1D2C3B4A));
      repeat (3) @(negedge clk);
      chk(res_valid === 1'b0, "R1 valid in reset", 512'(res_valid), 512'(0));
      chk(res_data === '0, "R1 data in reset", res_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_lane_mask === '0, "R1 mask after reset", 512'(res_lane_mask), '0);
      chk(res_valid === 1'b0, "R1 valid after reset", 512'(res_valid), 512'(0));

      for (int r = 0; r < 16; r++) write_row(r, rnd512());

      do_req({16'd0, 16'd3}, 1'b0, 7'd64, 5'd16, "R3 raw full row");
      do_req({16'd0, 16'd15}, 1'b1, 7'd64, 5'd16, "R3 dword full row");
      do_req({16'd0, 16'd2}, 1'b0, 7'd6, 5'd16, "R4 raw width 6");
      do_req({16'd0, 16'd2}, 1'b1, 7'd6, 5'd16, "R5 dword width 6");
      do_req({16'd0, 16'd9}, 1'b0, 7'd61, 5'd16, "R4 raw width 61");
      do_req({16'd0, 16'd9}, 1'b1, 7'd61, 5'd16, "R5 dword width 61");
      do_req({16'd0, 16'd1}, 1'b0, 7'd0, 5'd16, "R4 width 0");
      do_req({16'd0, 16'd4}, 1'b0, 7'd100, 5'd16, "R7 raw width 100");
      do_req({16'd0, 16'd4}, 1'b1, 7'd127, 5'd16, "R7 dword width 127");
      do_req({16'd1, 16'd0}, 1'b0, 7'd64, 5'd16, "R9 chunk 1");
      do_req({16'hFFFF, 16'd0}, 1'b1, 7'd127, 5'd16, "R9 chunk max");
      do_req({16'd0, 16'd16}, 1'b0, 7'd64, 5'd16, "R6 row 16");
      do_req({16'd0, 16'hFFFF}, 1'b1, 7'd64, 5'd16, "R6 row max");
      do_req({16'd0, 16'd5}, 1'b0, 7'd64, 5'd5, "R6 row equals count");
      do_req({16'd0, 16'd4}, 1'b0, 7'd64, 5'd5, "R6 row below count");

      held = res_data;
      @(negedge clk);
      chk(res_valid === 1'b0, "R2 idle no valid", 512'(res_valid), 512'(0));
      chk(res_data === held, "R2 idle data held", res_data, held);

      write_row(7, rnd512());
      do_req({16'd0, 16'd7}, 1'b0, 7'd64, 5'd16, "R10 write visible");

      for (int n = 0; n < 400; n++) begin
         logic [31:0] s;
         s[15:0]  = ($urandom % 4 == 0) ? 16'($urandom % 20) : 16'($urandom % 16);
         s[31:16] = ($urandom % 6 == 0) ? 16'($urandom) : 16'd0;
         do_req(s, 1'($urandom), 7'($urandom % 72), 5'($urandom % 17),
                "R4 R5 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule